// File: doc/BRIEF.md
# Transceiver Reset Sequencer

This block drives the reset and clock-recovery steering lines of a bonded group of serial transceiver channels, where every channel has a transmitter and a receiver. Each receiver's clock-data-recovery circuit is steered by hand rather than by its own lock detector. After the block's own reset it holds the transmit PLL in reset for a fixed time, then waits for PLL lock. It releases the transmit side first. Once the reconfiguration logic is idle it releases the receive analog reset.

The block then keeps every recovery circuit tracking the reference clock for a fixed interval, switches them all to track incoming data, and releases the receive digital path after a second interval plus a two-cycle settle step. A loss of PLL lock, or a request from the surrounding logic, restarts the whole sequence from the fully-reset state. All intervals are cycle counts set by parameters. The PLL hold time comes from the clock frequency in MHz multiplied by the hold time in microseconds.

The PLL lock and reconfiguration busy inputs are asynchronous. Each passes through a two-stage synchronizer before the state machine uses it.

Top module: `xcvr_rst_seq`

## Requirements
- R1: Each time the sequence starts, after block reset release or after a restart, `pll_rst` stays high for exactly PLL_CYC = CLK_MHZ × PLL_RST_US clock cycles and then falls.
- R2: While `pll_rst` is high, `tx_dig_rst`, `rx_ana_rst` and `rx_dig_rst` are all 1, every bit of `cdr_ref_lock` is 1, every bit of `cdr_data_lock` is 0, and `seq_done` is 0.
- R3: After `pll_rst` falls, `tx_dig_rst` stays 1 for as long as `pll_locked` is low. Once `pll_locked` goes high, `tx_dig_rst` falls within 3 clock cycles.
- R4: `rx_ana_rst` falls only after `tx_dig_rst` has fallen. It stays 1 while `reconfig_busy` is high, and it falls within 3 clock cycles once `reconfig_busy` is low with the PLL locked.
- R5: The sequence reaches completion with `reconfig_busy` held low throughout. No busy pulse is required.
- R6: From the first cycle with `rx_ana_rst` low, all `cdr_ref_lock` bits stay 1 for exactly LTR_CYC cycles. In the cycle when they drop to 0, all `cdr_data_lock` bits rise to 1, and the two vectors are never nonzero at the same time.
- R7: `rx_dig_rst` falls exactly LTD_CYC + SETTLE_CYC cycles after the switch to data lock, where SETTLE_CYC is 2. During that time `cdr_data_lock` stays all ones.
- R8: `seq_done` is 1 exactly when all four resets are 0 and `cdr_data_lock` is all ones.
- R9: If `pll_locked` falls in any state after lock was seen, the block is back in the fully-reset state of R2 within 3 cycles and restarts as in R1.
- R10: A high `rst_req` sampled on a clock edge puts the block in the fully-reset state at that edge and restarts the sequence as in R1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rst_req | input | 1 | Synchronous request to restart the sequence |
| pll_locked | input | 1 | PLL lock status (asynchronous) |
| reconfig_busy | input | 1 | Reconfiguration busy flag (asynchronous) |
| pll_rst | output | 1 | PLL reset |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receive analog reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| cdr_ref_lock | output | N_CH | Per-channel steer of recovery to the reference clock |
| cdr_data_lock | output | N_CH | Per-channel steer of recovery to incoming data |
| seq_done | output | 1 | Sequence complete |

## Verification
The sequence is driven with several input patterns:
- **Busy high across PLL lock:** the bench holds busy high while lock arrives. This separates the transmit release from the receive analog release.
- **Busy never asserted:** this shows that the block does not wait for a pulse that may not come.
- **Lock withheld for a long time:** this shows that the block has no timeout that skips the lock wait.
- **Lock dropped, and restart request:** the bench drops lock both after completion and in the middle of the reference-lock phase, and pulses the restart request after completion. The full PLL hold time is re-measured after each restart.

Every phase length is counted sample by sample. An off-by-one in any timer therefore shows up as a wrong count rather than only as a wrong order.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        ST_PLL_RST,
        ST_LOCK_WAIT,
        ST_BUSY_WAIT,
        ST_REF_LOCK,
        ST_DATA_LOCK,
        ST_SETTLE,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic pll_rst;
        logic tx_rst;
        logic rxa_rst;
        logic rxd_rst;
        logic ref_lock;
        logic data_lock;
        logic done;
    } seq_out_t;

    function automatic seq_out_t decode_outputs(seq_state_e s);
        seq_out_t o;
        o.pll_rst   = (s == ST_PLL_RST);
        o.tx_rst    = (s == ST_PLL_RST) || (s == ST_LOCK_WAIT);
        o.rxa_rst   = o.tx_rst || (s == ST_BUSY_WAIT);
        o.ref_lock  = o.rxa_rst || (s == ST_REF_LOCK);
        o.data_lock = (s == ST_DATA_LOCK) || (s == ST_SETTLE) || (s == ST_RUN);
        o.rxd_rst   = (s != ST_RUN);
        o.done      = (s == ST_RUN);
        return o;
    endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int STAGES = 2,
    parameter int W      = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
    parameter int              CW      = 8,
    parameter logic [CW-1:0]   RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)            cnt_d = load_val;
        else if (cnt_q != 0) cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xrs_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int CLK_MHZ    = 50,
    parameter int PLL_RST_US = 1,
    parameter int LTR_CYC    = 40,
    parameter int LTD_CYC    = 30,
    parameter int SETTLE_CYC = 2,
    parameter int SYNC_STG   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req,
    input  logic            pll_locked,
    input  logic            reconfig_busy,
    output logic            pll_rst,
    output logic            tx_dig_rst,
    output logic            rx_ana_rst,
    output logic            rx_dig_rst,
    output logic [N_CH-1:0] cdr_ref_lock,
    output logic [N_CH-1:0] cdr_data_lock,
    output logic            seq_done
);
    localparam int PLL_CYC = CLK_MHZ * PLL_RST_US;
    localparam int MAX_A   = (PLL_CYC > LTR_CYC) ? PLL_CYC : LTR_CYC;
    localparam int MAX_B   = (LTD_CYC > SETTLE_CYC) ? LTD_CYC : SETTLE_CYC;
    localparam int MAXC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW      = $clog2(MAXC + 1);

    typedef struct packed {
        seq_state_e st;
        seq_out_t   o;
    } seq_reg_t;

    localparam seq_reg_t SEQ_RST = '{st: ST_PLL_RST, o: decode_outputs(ST_PLL_RST)};

    seq_reg_t      seq_d, seq_q;
    logic          tmr_ld;
    logic [CW-1:0] tmr_val;
    logic          tmr_exp;
    logic [1:0]    async_in, sync_out;
    logic          lock_s, busy_s;

    assign async_in = {reconfig_busy, pll_locked};

    xrs_sync #(.STAGES(SYNC_STG), .W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_in),
        .q     (sync_out)
    );
    assign lock_s = sync_out[0];
    assign busy_s = sync_out[1];

    xrs_timer #(.CW(CW), .RST_VAL(CW'(PLL_CYC))) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_ld),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        seq_d   = seq_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        if (rst_req) begin
            seq_d.st = ST_PLL_RST;
            tmr_ld   = 1'b1;
            tmr_val  = CW'(PLL_CYC - 1);
        end else begin
            unique case (seq_q.st)
                ST_PLL_RST: begin
                    if (tmr_exp) seq_d.st = ST_LOCK_WAIT;
                end
                ST_LOCK_WAIT: begin
                    if (lock_s) seq_d.st = ST_BUSY_WAIT;
                end
                default: begin
                    if (!lock_s) begin
                        seq_d.st = ST_PLL_RST;
                        tmr_ld   = 1'b1;
                        tmr_val  = CW'(PLL_CYC - 1);
                    end else begin
                        unique case (seq_q.st)
                            ST_BUSY_WAIT: if (!busy_s) begin
                                seq_d.st = ST_REF_LOCK;
                                tmr_ld   = 1'b1;
                                tmr_val  = CW'(LTR_CYC - 1);
                            end
                            ST_REF_LOCK: if (tmr_exp) begin
                                seq_d.st = ST_DATA_LOCK;
                                tmr_ld   = 1'b1;
                                tmr_val  = CW'(LTD_CYC - 1);
                            end
                            ST_DATA_LOCK: if (tmr_exp) begin
                                seq_d.st = ST_SETTLE;
                                tmr_ld   = 1'b1;
                                tmr_val  = CW'(SETTLE_CYC - 1);
                            end
                            ST_SETTLE: if (tmr_exp) begin
                                seq_d.st = ST_RUN;
                            end
                            default: seq_d.st = seq_q.st;
                        endcase
                    end
                end
            endcase
        end
        seq_d.o = decode_outputs(seq_d.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign pll_rst    = seq_q.o.pll_rst;
    assign tx_dig_rst = seq_q.o.tx_rst;
    assign rx_ana_rst = seq_q.o.rxa_rst;
    assign rx_dig_rst = seq_q.o.rxd_rst;
    assign seq_done   = seq_q.o.done;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_lane
        assign cdr_ref_lock[ch]  = seq_q.o.ref_lock;
        assign cdr_data_lock[ch] = seq_q.o.data_lock;
    end
endmodule

// File: rtl/xrs_chk.sv
module xrs_chk #(
    parameter int N_CH = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pll_rst,
    input logic            tx_dig_rst,
    input logic            rx_ana_rst,
    input logic            rx_dig_rst,
    input logic [N_CH-1:0] cdr_ref_lock,
    input logic [N_CH-1:0] cdr_data_lock,
    input logic            seq_done
);
    // R2
    pll_hold_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_rst |-> (tx_dig_rst && rx_ana_rst && rx_dig_rst && (&cdr_ref_lock)
                     && (cdr_data_lock == '0) && !seq_done));

    // R3
    tx_after_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_rst) |-> tx_dig_rst);

    // R4
    rxa_after_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_ana_rst |-> !tx_dig_rst);

    // R6
    lock_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdr_ref_lock == '0) || (cdr_data_lock == '0));

    // R6
    lock_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cdr_ref_lock[0]) && !pll_rst) |-> (&cdr_data_lock));

    // R7
    rxd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_dig_rst) |-> ((&cdr_data_lock) && $past(&cdr_data_lock)));

    // R8
    done_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> (!pll_rst && !tx_dig_rst && !rx_ana_rst && !rx_dig_rst
                      && (&cdr_data_lock)));
endmodule

bind xcvr_rst_seq xrs_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/xcvr_rst_seq_tb.sv
module xcvr_rst_seq_tb;
    localparam int N_CH    = 4;
    localparam int PLL_CYC = 50;
    localparam int LTR     = 40;
    localparam int LTD     = 30;
    localparam int SETTLE  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rst_req = 1'b0;
    logic            pll_locked = 1'b0;
    logic            reconfig_busy = 1'b1;
    logic            pll_rst, tx_dig_rst, rx_ana_rst, rx_dig_rst, seq_done;
    logic [N_CH-1:0] cdr_ref_lock, cdr_data_lock;

    int checks = 0;
    int errors = 0;

    always #10ns clk = ~clk;

    xcvr_rst_seq #(.N_CH(N_CH), .CLK_MHZ(50), .PLL_RST_US(1), .LTR_CYC(LTR),
                   .LTD_CYC(LTD), .SETTLE_CYC(SETTLE), .SYNC_STG(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .pll_locked(pll_locked),
        .reconfig_busy(reconfig_busy), .pll_rst(pll_rst), .tx_dig_rst(tx_dig_rst),
        .rx_ana_rst(rx_ana_rst), .rx_dig_rst(rx_dig_rst), .cdr_ref_lock(cdr_ref_lock),
        .cdr_data_lock(cdr_data_lock), .seq_done(seq_done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit full_reset();
        return pll_rst && tx_dig_rst && rx_ana_rst && rx_dig_rst &&
               (cdr_ref_lock == '1) && (cdr_data_lock == '0) && !seq_done;
    endfunction

    // Counts samples, starting with the current one, while pll_rst is high (R1, R2)
    task automatic measure_pll_hold(input string tag);
        int n = 0;
        bit others_ok = 1'b1;
        while (pll_rst && n < 10 * PLL_CYC) begin
            if (!full_reset()) others_ok = 1'b0;
            n++;
            @(negedge clk);
        end
        chk(n == PLL_CYC, {tag, " R1 pll hold cycles"}, n, PLL_CYC);
        chk(others_ok, {tag, " R2 outputs during pll hold"}, int'(others_ok), 1);
    endtask

    // From a sample in the busy-wait state, waits for rx_ana_rst to fall and
    // then measures the lock phases (R6, R7, R8)
    task automatic measure_rx_phases(input string tag);
        int n = 0;
        int w = 0;
        while (rx_ana_rst && w < 1000) begin
            @(negedge clk);
            w++;
        end
        chk(!rx_ana_rst, {tag, " R4 rx analog release"}, int'(rx_ana_rst), 0);
        while (cdr_ref_lock == '1 && cdr_data_lock == '0 && n < 10 * LTR) begin
            n++;
            @(negedge clk);
        end
        chk(n == LTR, {tag, " R6 ref-lock cycles"}, n, LTR);
        chk(cdr_ref_lock == '0 && cdr_data_lock == '1, {tag, " R6 swap same edge"},
            int'(cdr_data_lock), (1 << N_CH) - 1);
        n = 0;
        while (rx_dig_rst && cdr_data_lock == '1 && n < 10 * LTD) begin
            chk(!seq_done, {tag, " R8 done low before release"}, int'(seq_done), 0);
            n++;
            @(negedge clk);
        end
        chk(n == LTD + SETTLE, {tag, " R7 data-lock to rx digital release"}, n, LTD + SETTLE);
        chk(seq_done && !pll_rst && !tx_dig_rst && !rx_ana_rst && !rx_dig_rst &&
            cdr_data_lock == '1, {tag, " R8 done with all released"}, int'(seq_done), 1);
    endtask

    task automatic t_power_up();
        rst_n = 1'b0;
        pll_locked = 1'b0;
        reconfig_busy = 1'b1;
        repeat (3) @(negedge clk);
        chk(full_reset(), "R2 state during block reset", int'(pll_rst), 1);
        rst_n = 1'b1;
        @(negedge clk);
        measure_pll_hold("power-up");
    endtask

    task automatic t_lock_then_busy();
        int w = 0;
        repeat (200) @(negedge clk);
        chk(tx_dig_rst && !pll_rst, "R3 tx held while unlocked", int'(tx_dig_rst), 1);
        pll_locked = 1'b1;
        while (tx_dig_rst && w < 10) begin
            @(negedge clk);
            w++;
        end
        chk(w <= 3 && !tx_dig_rst, "R3 tx release latency", w, 3);
        repeat (60) @(negedge clk);
        chk(rx_ana_rst && !tx_dig_rst, "R4 rx analog held while busy", int'(rx_ana_rst), 1);
        reconfig_busy = 1'b0;
        w = 0;
        while (rx_ana_rst && w < 10) begin
            @(negedge clk);
            w++;
        end
        chk(w <= 3 && !rx_ana_rst, "R4 rx analog release latency", w, 3);
        measure_rx_phases("busy-pulse");
    endtask

    task automatic t_lock_loss_done();
        int w = 0;
        pll_locked = 1'b0;
        while (!pll_rst && w < 10) begin
            @(negedge clk);
            w++;
        end
        chk(w <= 3 && full_reset(), "R9 restart after lock loss in run", w, 3);
        measure_pll_hold("lock-loss");
    endtask

    task automatic t_no_busy();
        repeat (5) @(negedge clk);
        pll_locked = 1'b1;
        measure_rx_phases("R5 no-busy");
        chk(seq_done, "R5 completion without busy pulse", int'(seq_done), 1);
    endtask

    task automatic t_restart_req();
        rst_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        chk(full_reset(), "R10 restart on request", int'(pll_rst), 1);
        measure_pll_hold("R10 request");
    endtask

    task automatic t_lock_loss_mid();
        int w = 0;
        while (rx_ana_rst && w < 1000) begin
            @(negedge clk);
            w++;
        end
        repeat (10) @(negedge clk);
        chk(cdr_ref_lock == '1 && !rx_ana_rst, "R9 in ref-lock phase", int'(cdr_ref_lock), (1 << N_CH) - 1);
        pll_locked = 1'b0;
        w = 0;
        while (!pll_rst && w < 10) begin
            @(negedge clk);
            w++;
        end
        chk(w <= 3 && full_reset(), "R9 restart mid ref-lock", w, 3);
        measure_pll_hold("R9 mid");
        pll_locked = 1'b1;
        measure_rx_phases("R9 recovery");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_power_up();
        t_lock_then_busy();
        t_lock_loss_done();
        t_no_busy();
        t_restart_req();
        t_lock_loss_mid();
        repeat (5) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule